// File: doc/BRIEF.md
# Machine-Cycle Bus Strobe Generator

This block sets the machine-cycle rhythm of an 8-bit controller core. It divides the oscillator clock into numbered phase slots and drives two bus strobes from them:

- an active-high address-latch strobe;
- an active-low code-read strobe, which clocks external program memory.

A machine cycle takes 12 oscillator clocks in normal mode. In double-speed mode it takes 6 clocks, so the core keeps the same throughput from half the oscillator frequency.

Several attributes are captured once, when a machine cycle begins, and hold for the whole cycle:

- the speed mode;
- whether the core is fetching code externally;
- whether the cycle is an external data transfer.

On a data-transfer cycle the first latch pulse and both code-read pulses are withheld. Software can silence the latch strobe by writing a configuration bit, which parks the strobe high. That bit is ignored while the core fetches code externally, because the external memory needs the strobe.

A raw reset pin is qualified before it reaches the core. The core reset is raised only after the pin has stayed high for two full normal-mode machine cycles.

Top module: `mcycle_strobe_gen`

## Requirements
- R1: `core_rst` rises after `rst_pin` has been sampled high on 24 consecutive rising edges (two 12-clock machine cycles), not sooner. It falls on the first edge at which the pin is sampled low. A high pulse shorter than 24 edges never raises it.
- R2: While `core_rst` is high, `addr_latch` is 1, `code_rd_n` is 1 and `slot_idx` is 0.
- R3: In normal mode, `slot_idx` steps 0,1,…,11 and then wraps to 0. `cyc_start` is high exactly when `slot_idx` is 0. The first slot 0 begins on the edge that clears `core_rst`.
- R4: In a normal-mode cycle that is not a data transfer, `addr_latch` is high for one clock at slot 0 and for one clock at slot 6, and low in every other slot. This gives one pulse every 6 clocks.
- R5: In double-speed mode (`dbl_active`=1), a cycle is 6 slots (0..5). The latch strobe is high at slots 0 and 3. The code-read strobe, when enabled, is low at slots 1 and 4.
- R6: In a normal cycle with external fetch sampled high and no data transfer, `code_rd_n` is low for one clock at slot 3 and for one clock at slot 9. When external fetch is sampled low, `code_rd_n` stays high for the whole cycle.
- R7: In a data-transfer cycle, the latch pulse at slot 0 is withheld, the mid-cycle latch pulse (slot 6, or slot 3 in double speed) is kept, and `code_rd_n` stays high.
- R8: `dbl_sel`, `ext_exec` and `xdata_req` are sampled only on the edge that starts slot 0. Changing them during a cycle does not change that cycle's length or its strobe pattern.
- R9: A write with `cfg_wr_addr`=8'h8E sets or clears the latch-disable bit from bit 0 of `cfg_wr_data`. While the bit is set and the cycle is not an external-fetch cycle, `addr_latch` stays 1 in every slot. Writes to any other address leave the bit unchanged.
- R10: In an external-fetch cycle the latch-disable bit has no effect, and the strobe pattern of R4, R5 and R7 applies.
- R11: Qualified reset clears the latch-disable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw reset pin, active high |
| xdata_req | input | 1 | Next machine cycle is an external data transfer |
| ext_exec | input | 1 | Core is fetching code from external memory |
| dbl_sel | input | 1 | Selects 6-clock machine cycles |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Configuration write address |
| cfg_wr_data | input | 8 | Configuration write data (bit 0 used) |
| core_rst | output | 1 | Qualified reset for the core |
| addr_latch | output | 1 | Address-latch strobe, active high |
| code_rd_n | output | 1 | Code-read strobe, active low |
| slot_idx | output | 4 | Current phase slot within the machine cycle |
| cyc_start | output | 1 | High in slot 0 of each machine cycle |
| dbl_active | output | 1 | Current cycle runs in double-speed mode |

## Verification
The assertions assume that the core changes `dbl_sel`, `ext_exec` and `xdata_req` freely, with no other constraint, and that a configuration write lasts one clock. They also assume that the pin reset, not some earlier state, starts the slot count. The stimulus therefore begins with a full pin reset and changes every input on the falling clock edge. Attribute changes fall in the last slot of a cycle, except in the deliberate mid-cycle flip cases. Those flips test the boundary sampling against patterns worked out from the slot arithmetic.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    localparam int unsigned MCS_NORM_SLOTS = 12;
    localparam logic [7:0]  MCS_CTL_ADDR   = 8'h8E;

    // number of slots in one machine cycle for the given mode
    function automatic int unsigned slots_of(input logic dbl, input int unsigned norm);
        return dbl ? norm / 2 : norm;
    endfunction
endpackage

// File: rtl/mcs_reset_qual.sv
module mcs_reset_qual #(
    parameter int unsigned HOLD = 24
) (
    input  logic clk,
    input  logic rst_pin,
    output logic rst_q,
    output logic rst_d
);
    localparam int unsigned CW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rst;
    } qual_t;

    qual_t q, n;

    always_comb begin
        n = q;
        if (!rst_pin) begin
            n.cnt = '0;
            n.rst = 1'b0;
        end else begin
            n.cnt = (q.cnt == CW'(HOLD)) ? q.cnt : q.cnt + 1'b1;
            n.rst = (q.cnt >= CW'(HOLD - 1));
        end
    end

    always_ff @(posedge clk) begin
        q <= n;
    end

    assign rst_q = q.rst;
    assign rst_d = n.rst;

    // reset may only appear once the full hold window has been counted
    assert_full_hold_R1: assert property (@(posedge clk) disable iff (!rst_pin)
        $rose(q.rst) |-> (q.cnt == CW'(HOLD)))
        else $error("core reset raised before hold window elapsed");
endmodule

// File: rtl/mcs_latch_cfg.sv
module mcs_latch_cfg #(
    parameter logic [7:0] CTL_ADDR = 8'h8E
) (
    input  logic       clk,
    input  logic       core_rst_q,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       dis_q,
    output logic       dis_d
);
    logic hit;

    always_comb begin
        hit   = wr_en && (wr_addr == CTL_ADDR);
        dis_d = dis_q;
        if (core_rst_q)
            dis_d = 1'b0;
        else if (hit)
            dis_d = wr_data[0];
    end

    always_ff @(posedge clk) begin
        dis_q <= dis_d;
    end

    assert_foreign_write_ignored_R9: assert property (@(posedge clk) disable iff (core_rst_q)
        (wr_en && wr_addr != CTL_ADDR) |=> $stable(dis_q))
        else $error("disable bit changed by write to another address");
endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer #(
    parameter int unsigned NORM_SLOTS = 12,
    localparam int unsigned SW = $clog2(NORM_SLOTS)
) (
    input  logic          clk,
    input  logic          core_rst_q,
    input  logic          core_rst_d,
    input  logic          dis_d,
    input  logic          dbl_sel,
    input  logic          xdata_req,
    input  logic          ext_exec,
    output logic [SW-1:0] slot_q,
    output logic          dbl_q,
    output logic          latch_q,
    output logic          code_rd_q
);
    localparam int unsigned N_HALF = NORM_SLOTS / 2;
    localparam int unsigned N_QTR  = N_HALF / 2;
    localparam int unsigned D_SLOTS = NORM_SLOTS / 2;
    localparam int unsigned D_HALF = D_SLOTS / 2;
    localparam int unsigned D_QTR  = D_HALF / 2;

    typedef struct packed {
        logic [SW-1:0] slot;
        logic          dbl;
        logic          xd;
        logic          ext;
        logic          latch;
        logic          rd;
    } seq_t;

    seq_t q, n;
    logic [SW-1:0] last_q, half_n, qtr_n, half_q;
    logic          wrap;

    always_comb begin
        last_q = q.dbl ? SW'(D_SLOTS - 1) : SW'(NORM_SLOTS - 1);
        half_q = q.dbl ? SW'(D_HALF) : SW'(N_HALF);
        wrap   = core_rst_q || (q.slot == last_q);
        n      = q;
        half_n = '0;
        qtr_n  = '0;
        if (core_rst_d) begin
            n.slot  = '0;
            n.dbl   = dbl_sel;
            n.xd    = 1'b0;
            n.ext   = ext_exec;
            n.latch = 1'b1;
            n.rd    = 1'b0;
        end else begin
            if (wrap) begin
                n.slot = '0;
                n.dbl  = dbl_sel;
                n.xd   = xdata_req;
                n.ext  = ext_exec;
            end else begin
                n.slot = q.slot + 1'b1;
            end
            half_n  = n.dbl ? SW'(D_HALF) : SW'(N_HALF);
            qtr_n   = n.dbl ? SW'(D_QTR) : SW'(N_QTR);
            n.latch = (dis_d && !n.ext)
                    || (n.slot == '0 && !n.xd)
                    || (n.slot == half_n);
            n.rd    = n.ext && !n.xd
                    && (n.slot == qtr_n || n.slot == half_n + qtr_n);
        end
    end

    always_ff @(posedge clk) begin
        q <= n;
    end

    assign slot_q    = q.slot;
    assign dbl_q     = q.dbl;
    assign latch_q   = q.latch;
    assign code_rd_q = q.rd;

    always_ff @(posedge clk) begin
        if (core_rst_q) begin
            assert_idle_in_reset_R2: assert (q.latch && !q.rd && q.slot == '0)
                else $error("strobes active during reset");
        end
    end

    assert_read_pulse_single_R6: assert property (@(posedge clk) disable iff (core_rst_q)
        q.rd |=> !q.rd)
        else $error("code read longer than one slot");

    assert_no_read_on_data_R7: assert property (@(posedge clk) disable iff (core_rst_q)
        q.xd |-> !q.rd)
        else $error("code read during data transfer cycle");

    assert_mode_held_R8: assert property (@(posedge clk) disable iff (core_rst_q)
        (q.slot != '0) |-> ($stable(q.dbl) && $stable(q.ext) && $stable(q.xd)))
        else $error("cycle attributes changed mid-cycle");

    assert_latch_kept_external_R10: assert property (@(posedge clk) disable iff (core_rst_q)
        (q.ext && q.slot == half_q) |-> q.latch)
        else $error("latch strobe missing during external fetch");
endmodule

// File: rtl/mcycle_strobe_gen.sv
module mcycle_strobe_gen #(
    parameter int unsigned NORM_SLOTS = mcs_pkg::MCS_NORM_SLOTS,
    parameter logic [7:0]  CTL_ADDR   = mcs_pkg::MCS_CTL_ADDR,
    localparam int unsigned SW = $clog2(NORM_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_pin,
    input  logic          xdata_req,
    input  logic          ext_exec,
    input  logic          dbl_sel,
    input  logic          cfg_wr_en,
    input  logic [7:0]    cfg_wr_addr,
    input  logic [7:0]    cfg_wr_data,
    output logic          core_rst,
    output logic          addr_latch,
    output logic          code_rd_n,
    output logic [SW-1:0] slot_idx,
    output logic          cyc_start,
    output logic          dbl_active
);
    localparam int unsigned HOLD = 2 * mcs_pkg::slots_of(1'b0, NORM_SLOTS);

    logic rst_q, rst_d, dis_q, dis_d, latch_q, code_rd_q;

    mcs_reset_qual #(.HOLD(HOLD)) u_qual (
        .clk     (clk),
        .rst_pin (rst_pin),
        .rst_q   (rst_q),
        .rst_d   (rst_d)
    );

    mcs_latch_cfg #(.CTL_ADDR(CTL_ADDR)) u_cfg (
        .clk        (clk),
        .core_rst_q (rst_q),
        .wr_en      (cfg_wr_en),
        .wr_addr    (cfg_wr_addr),
        .wr_data    (cfg_wr_data),
        .dis_q      (dis_q),
        .dis_d      (dis_d)
    );

    mcs_sequencer #(.NORM_SLOTS(NORM_SLOTS)) u_seq (
        .clk        (clk),
        .core_rst_q (rst_q),
        .core_rst_d (rst_d),
        .dis_d      (dis_d),
        .dbl_sel    (dbl_sel),
        .xdata_req  (xdata_req),
        .ext_exec   (ext_exec),
        .slot_q     (slot_idx),
        .dbl_q      (dbl_active),
        .latch_q    (latch_q),
        .code_rd_q  (code_rd_q)
    );

    assign core_rst   = rst_q;
    assign addr_latch = latch_q;
    assign code_rd_n  = ~code_rd_q;
    assign cyc_start  = (slot_idx == '0) && !rst_q;

    assert_disable_cleared_R11: assert property (@(posedge clk) disable iff (!rst_q)
        rst_q |=> !dis_q)
        else $error("disable bit survived reset");
endmodule

// File: tb/mcycle_strobe_gen_test.sv
module mcycle_strobe_gen_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_pin = 1'b0, xdata_req = 1'b0, ext_exec = 1'b0, dbl_sel = 1'b0, cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_addr = 8'h00, cfg_wr_data = 8'h00;
    logic       core_rst, addr_latch, code_rd_n, cyc_start, dbl_active;
    logic [3:0] slot_idx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit dis_m = 1'b0;

    mcycle_strobe_gen uut (
        .clk(clk), .rst_pin(rst_pin), .xdata_req(xdata_req), .ext_exec(ext_exec),
        .dbl_sel(dbl_sel), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
        .cfg_wr_data(cfg_wr_data), .core_rst(core_rst), .addr_latch(addr_latch),
        .code_rd_n(code_rd_n), .slot_idx(slot_idx), .cyc_start(cyc_start),
        .dbl_active(dbl_active)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_latch(bit d, bit x, bit e, bit dis, int s);
        int h = (d ? 6 : 12) / 2;
        if (dis && !e) return 1'b1;
        return (s == 0 && !x) || (s == h);
    endfunction

    function automatic bit exp_rd_n(bit d, bit x, bit e, int s);
        int h = (d ? 6 : 12) / 2;
        int q = h / 2;
        return !(e && !x && (s == q || s == h + q));
    endfunction

    // drive attributes in the last slot, then check every slot of the new cycle
    task automatic run_cycle(input bit d, input bit x, input bit e, input bit wd,
                             input logic [7:0] wa, input bit flip, input string force_tag);
        int ns = d ? 6 : 12;
        string tl, tr, ts;
        while (slot_idx != (dbl_active ? 4'd5 : 4'd11)) @(negedge clk);
        dbl_sel = d; xdata_req = x; ext_exec = e;
        cfg_wr_en = (wa != 8'h00); cfg_wr_addr = wa; cfg_wr_data = {7'b0, wd};
        if (wa == 8'h8E) dis_m = wd;
        ts = d ? "R5" : "R3";
        tl = d ? "R5" : (x ? "R7" : ((dis_m && !e) ? "R9" : ((dis_m && e) ? "R10" : "R4")));
        tr = x ? "R7" : (d ? "R5" : "R6");
        if (flip) begin ts = "R8"; tl = "R8"; tr = "R8"; end
        if (force_tag != "") begin tl = force_tag; end
        for (int s = 0; s < ns; s++) begin
            @(negedge clk);
            if (s == 0) cfg_wr_en = 1'b0;
            chk(slot_idx == 4'(s), ts, "slot_idx", int'(slot_idx), s);
            chk(cyc_start == (s == 0), ts, "cyc_start", int'(cyc_start), int'(s == 0));
            chk(dbl_active == d, ts, "dbl_active", int'(dbl_active), int'(d));
            chk(addr_latch == exp_latch(d, x, e, dis_m, s), tl, "addr_latch",
                int'(addr_latch), int'(exp_latch(d, x, e, dis_m, s)));
            chk(code_rd_n == exp_rd_n(d, x, e, s), tr, "code_rd_n",
                int'(code_rd_n), int'(exp_rd_n(d, x, e, s)));
            if (flip && s == 2) begin
                dbl_sel = !d; xdata_req = !x; ext_exec = !e;
            end
        end
    endtask

    task automatic do_reset(input int hold);
        rst_pin = 1'b1;
        for (int k = 1; k <= hold; k++) begin
            @(negedge clk);
            chk(core_rst == (k >= 24), "R1", "core_rst while held", int'(core_rst), int'(k >= 24));
            if (k >= 24) begin
                chk(addr_latch == 1'b1, "R2", "addr_latch in reset", int'(addr_latch), 1);
                chk(code_rd_n == 1'b1, "R2", "code_rd_n in reset", int'(code_rd_n), 1);
                chk(slot_idx == 4'd0, "R2", "slot_idx in reset", int'(slot_idx), 0);
            end
        end
        rst_pin = 1'b0;
        @(negedge clk);
        chk(core_rst == 1'b0, "R1", "core_rst after release", int'(core_rst), 0);
        if (hold >= 24) begin
            dis_m = 1'b0;
            chk(slot_idx == 4'd0, "R3", "first slot after reset", int'(slot_idx), 0);
            chk(cyc_start == 1'b1, "R3", "cyc_start after reset", int'(cyc_start), 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        ext_exec = 1'b1;
        do_reset(30);
        for (int dv = 0; dv < 2; dv++)
            for (int d = 0; d < 2; d++)
                for (int x = 0; x < 2; x++)
                    for (int e = 0; e < 2; e++)
                        run_cycle(bit'(d), bit'(x), bit'(e), bit'(dv), 8'h8E, 1'b0, "");
        run_cycle(1'b0, 1'b0, 1'b1, 1'b0, 8'h8E, 1'b1, "");
        run_cycle(1'b1, 1'b1, 1'b0, 1'b0, 8'h8E, 1'b1, "");
        run_cycle(1'b0, 1'b0, 1'b0, 1'b0, 8'h8E, 1'b1, "");
        run_cycle(1'b0, 1'b0, 1'b0, 1'b1, 8'h8F, 1'b0, "R9");
        run_cycle(1'b0, 1'b0, 1'b0, 1'b1, 8'h8E, 1'b0, "R9");
        do_reset(26);
        run_cycle(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R11");
        do_reset(10);
        run_cycle(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, "");
        run_cycle(1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, "");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule